// File: doc/BRIEF.md
# DMA Tag Group Completion Status Unit

This block follows outstanding DMA commands by tag group and answers a processing core's questions about which groups have finished. Commands are entered into a small slot queue with a tag index and a transfer size. A finished command leaves the queue when a retirement pulse carries its tag. The core programs a 32-bit tag-group mask. It then writes an update request in one of three modes. Immediate mode reports the current state of the masked groups at once. Any mode waits until at least one masked group is idle. All mode waits until every masked group is idle.

The answer is a status word on a read channel whose count is 0 or 1. A deferred request is held until its condition is met. It then produces the word and clears itself. A group counts as busy only while it owns a queued entry of non-zero size. An empty queue satisfies every request at once and returns the whole mask.

Top module: `tag_status_unit`

## Requirements
- R1: After reset the mask reads 0, the status count is 0 and no request is pending, so queue activity alone never raises the count.
- R2: A mask write is read back unchanged on `mask_o` after the clock edge that takes it.
- R3: An accepted update request (value 0, 1 or 2) clears the status count at its clock edge. An any or all request whose condition is not yet met leaves the count at 0.
- R4: Request value 0 (immediate) sets the count to 1 at its edge. The word is the mask with every bit cleared whose tag owns a queued non-zero-size entry.
- R5: With an empty queue, a request of any mode sets the count to 1 at its edge with the full mask as the word. A previously pending request is consumed.
- R6: Request value 1 (any) is held until at least one masked group owns no non-zero-size entry. The count then rises at the next edge, with the mask minus busy groups as the word, and the request is cleared so that later retirements raise nothing.
- R7: Request value 2 (all) is held until no masked group owns a non-zero-size entry. The count then rises at the next edge with the full mask as the word.
- R8: A request value above 2 is ignored: the count, the word and any pending request are unchanged.
- R9: The queue holds at most 16 entries. `enq_ready_o` is low when it is full, and an entry offered while full is dropped.
- R10: A zero-size entry never marks its group busy, but it does keep the queue non-empty.
- R11: Reading with `stat_re_i` while the count is 1 clears the count at that edge, and the word stays unchanged.
- R12: A retirement pulse removes one queued entry carrying its tag, taking the lowest slot. A pulse whose tag has no entry is ignored.
- R13: A new accepted request replaces a pending one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mask_we_i | input | 1 | Tag mask write strobe |
| mask_wdata_i | input | 32 | Tag mask write value |
| mask_o | output | 32 | Tag mask readback |
| upd_we_i | input | 1 | Update request write strobe |
| upd_mode_i | input | 32 | Request value: 0 immediate, 1 any, 2 all, others ignored |
| stat_re_i | input | 1 | Status read strobe |
| stat_cnt_o | output | 1 | Status channel count (0 or 1) |
| stat_o | output | 32 | Status word, one bit per tag group |
| enq_valid_i | input | 1 | Queue a command |
| enq_tag_i | input | 5 | Tag of queued command |
| enq_size_i | input | 16 | Size of queued command |
| enq_ready_o | output | 1 | Queue has a free slot |
| ret_valid_i | input | 1 | Retirement pulse |
| ret_tag_i | input | 5 | Tag of retired command |

## Verification
Immediate and empty-queue answers come from a single register stage, so they are due one edge after the request write. A deferred answer needs the queue register to change first and the request logic to see the new busy vector after that. It is therefore due two edges after the retirement pulse that satisfies it. The bench drives inputs after the falling edge. It samples at the next falling edge for one-edge results and waits one more cycle for deferred ones. At the intermediate point it also confirms that the count is still 0, which catches both early and late answers.

// File: rtl/tsu_pkg.sv
package tsu_pkg;
  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_ANY  = 2'd1,
    PEND_ALL  = 2'd2
  } pend_e;

  localparam int unsigned REQ_IMM = 0;
  localparam int unsigned REQ_MAX = 2;
endpackage

// File: rtl/tsu_queue.sv
module tsu_queue #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned TAG_W  = 5,
  parameter int unsigned SIZE_W = 16,
  localparam int unsigned NTAG  = 1 << TAG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enq_valid_i,
  input  logic [TAG_W-1:0]  enq_tag_i,
  input  logic [SIZE_W-1:0] enq_size_i,
  input  logic              ret_valid_i,
  input  logic [TAG_W-1:0]  ret_tag_i,
  output logic              full_o,
  output logic              empty_o,
  output logic [NTAG-1:0]   busy_o
);
  localparam logic [DEPTH-1:0] ONE = {{(DEPTH-1){1'b0}}, 1'b1};

  logic [DEPTH-1:0] vld_q, nz_q, free, enq_oh, hit, ret_oh;
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic             enq_ok;

  assign full_o  = &vld_q;
  assign empty_o = ~|vld_q;
  assign enq_ok  = enq_valid_i & ~full_o;
  assign free    = ~vld_q;
  assign enq_oh  = free & (~free + ONE);
  assign ret_oh  = ret_valid_i ? (hit & (~hit + ONE)) : '0;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign hit[i] = vld_q[i] && (tag_q[i] == ret_tag_i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[i] <= 1'b0;
        nz_q[i]  <= 1'b0;
        tag_q[i] <= '0;
      end else if (enq_ok && enq_oh[i]) begin
        vld_q[i] <= 1'b1;
        nz_q[i]  <= |enq_size_i;
        tag_q[i] <= enq_tag_i;
      end else if (ret_oh[i]) begin
        vld_q[i] <= 1'b0;
      end
    end
  end

  // zero-size entries hold a slot but never a group
  always_comb begin
    busy_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (vld_q[i] && nz_q[i]) busy_o[tag_q[i]] = 1'b1;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enq_valid_i && full_o && !ret_valid_i) |=> $stable(vld_q)); // R9
  AST_RET_NO_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_valid_i && !(|hit) && !enq_ok) |=> $stable(vld_q)); // R12
  AST_RET_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_valid_i && (|hit) && !enq_valid_i) |=>
      ($countones(vld_q) + 1 == $countones($past(vld_q)))); // R12
  AST_EMPTY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> (busy_o == '0)); // R10
endmodule

// File: rtl/tsu_req_ctrl.sv
module tsu_req_ctrl
  import tsu_pkg::*;
#(
  parameter int unsigned NTAG  = 32,
  parameter int unsigned REQ_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mask_we_i,
  input  logic [NTAG-1:0]  mask_wdata_i,
  input  logic             upd_we_i,
  input  logic [REQ_W-1:0] upd_mode_i,
  input  logic             stat_re_i,
  input  logic [NTAG-1:0]  busy_i,
  input  logic             empty_i,
  output logic [NTAG-1:0]  mask_o,
  output logic             stat_vld_o,
  output logic [NTAG-1:0]  stat_o
);
  logic [NTAG-1:0] mask_q, avail;
  pend_e           pend_q, mode_in;
  logic            upd_ok, upd_imm, fire;

  assign mask_o  = mask_q;
  assign avail   = mask_q & ~busy_i;
  assign upd_ok  = upd_we_i && (upd_mode_i <= REQ_W'(REQ_MAX));
  assign upd_imm = (upd_mode_i == REQ_W'(REQ_IMM)) || empty_i;
  assign mode_in = pend_e'(upd_mode_i[1:0]);

  always_comb begin
    unique case (pend_q)
      PEND_ANY: fire = (|avail) || empty_i;
      PEND_ALL: fire = ~|(mask_q & busy_i);
      default:  fire = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= PEND_NONE;
      stat_vld_o <= 1'b0;
      stat_o     <= '0;
    end else if (upd_ok) begin
      if (upd_imm) begin
        pend_q     <= PEND_NONE;
        stat_vld_o <= 1'b1;
        stat_o     <= avail;
      end else begin
        pend_q     <= mode_in;
        stat_vld_o <= 1'b0;
      end
    end else if (fire) begin
      pend_q     <= PEND_NONE;
      stat_vld_o <= 1'b1;
      stat_o     <= avail;
    end else if (stat_re_i) begin
      stat_vld_o <= 1'b0;
    end
  end

  AST_IMM_REPORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_we_i && upd_mode_i == 0) |=> stat_vld_o); // R4
  AST_REQ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_ok && !upd_imm) |=> !stat_vld_o); // R3
  AST_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_we_i && upd_mode_i > 2 && pend_q == PEND_NONE && !stat_re_i) |=>
      ($stable(stat_vld_o) && $stable(stat_o) && pend_q == PEND_NONE)); // R8
  AST_ALL_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pend_q == PEND_ALL && !upd_we_i) && $rose(stat_vld_o)) |->
      (stat_o == $past(mask_q))); // R7
  AST_ANY_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pend_q == PEND_ANY && !upd_we_i && !empty_i) && $rose(stat_vld_o)) |->
      (stat_o != '0)); // R6
  AST_PEND_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_vld_o) |-> (pend_q == PEND_NONE)); // R5
endmodule

// File: rtl/tag_status_unit.sv
module tag_status_unit #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned TAG_W  = 5,
  parameter int unsigned SIZE_W = 16,
  parameter int unsigned REQ_W  = 32,
  localparam int unsigned NTAG  = 1 << TAG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mask_we_i,
  input  logic [NTAG-1:0]   mask_wdata_i,
  output logic [NTAG-1:0]   mask_o,
  input  logic              upd_we_i,
  input  logic [REQ_W-1:0]  upd_mode_i,
  input  logic              stat_re_i,
  output logic              stat_cnt_o,
  output logic [NTAG-1:0]   stat_o,
  input  logic              enq_valid_i,
  input  logic [TAG_W-1:0]  enq_tag_i,
  input  logic [SIZE_W-1:0] enq_size_i,
  output logic              enq_ready_o,
  input  logic              ret_valid_i,
  input  logic [TAG_W-1:0]  ret_tag_i
);
  logic            full, empty;
  logic [NTAG-1:0] busy;

  assign enq_ready_o = ~full;

  tsu_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W), .SIZE_W(SIZE_W)) u_queue (
    .clk_i, .rst_ni,
    .enq_valid_i, .enq_tag_i, .enq_size_i,
    .ret_valid_i, .ret_tag_i,
    .full_o(full), .empty_o(empty), .busy_o(busy)
  );

  tsu_req_ctrl #(.NTAG(NTAG), .REQ_W(REQ_W)) u_ctrl (
    .clk_i, .rst_ni,
    .mask_we_i, .mask_wdata_i,
    .upd_we_i, .upd_mode_i, .stat_re_i,
    .busy_i(busy), .empty_i(empty),
    .mask_o, .stat_vld_o(stat_cnt_o), .stat_o
  );
endmodule

// File: tb/tag_status_unit_tb.sv
module tag_status_unit_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        mask_we = 0, upd_we = 0, stat_re = 0, enq_valid = 0, ret_valid = 0;
  logic [31:0] mask_wdata = 0, upd_mode = 0;
  logic [4:0]  enq_tag = 0, ret_tag = 0;
  logic [15:0] enq_size = 0;
  logic [31:0] mask_o, stat_o;
  logic        stat_cnt, enq_ready;

  int n_chk = 0, n_fail = 0;
  int nzc [32];
  int zc  [32];
  int total = 0;
  logic [31:0] m_mask = 0, seed = 32'h1234_5678;

  always #10 clk = ~clk;

  tag_status_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .mask_we_i(mask_we), .mask_wdata_i(mask_wdata), .mask_o(mask_o),
    .upd_we_i(upd_we), .upd_mode_i(upd_mode), .stat_re_i(stat_re),
    .stat_cnt_o(stat_cnt), .stat_o(stat_o),
    .enq_valid_i(enq_valid), .enq_tag_i(enq_tag), .enq_size_i(enq_size),
    .enq_ready_o(enq_ready), .ret_valid_i(ret_valid), .ret_tag_i(ret_tag)
  );

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic logic [31:0] mbusy();
    logic [31:0] b = 0;
    for (int t = 0; t < 32; t++) if (nzc[t] > 0) b[t] = 1'b1;
    return b;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic wmask(logic [31:0] v);
    mask_we = 1; mask_wdata = v; tick(); mask_we = 0; m_mask = v;
  endtask
  task automatic upd(logic [31:0] v);
    upd_we = 1; upd_mode = v; tick(); upd_we = 0;
  endtask
  task automatic rd();
    stat_re = 1; tick(); stat_re = 0;
  endtask
  task automatic enq(int t, int s);
    enq_valid = 1; enq_tag = 5'(t); enq_size = 16'(s); tick(); enq_valid = 0;
    if (total < 16) begin
      total++;
      if (s != 0) nzc[t]++; else zc[t]++;
    end
  endtask
  task automatic ret(int t);
    ret_valid = 1; ret_tag = 5'(t); tick(); ret_valid = 0;
    if (nzc[t] > 0) begin nzc[t]--; total--; end
    else if (zc[t] > 0) begin zc[t]--; total--; end
  endtask
  task automatic drain();
    for (int t = 0; t < 32; t++) while (nzc[t] + zc[t] > 0) ret(t);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int t = 0; t < 32; t++) begin nzc[t] = 0; zc[t] = 0; end
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk("R1 mask", mask_o, 0);
    chk("R1 count", 32'(stat_cnt), 0);
    enq(3, 8); ret(3); tick(); tick();
    chk("R1 no pending", 32'(stat_cnt), 0);

    // R2 mask readback sweep
    for (int i = 0; i < 8; i++) begin
      logic [31:0] v = rnd();
      wmask(v);
      chk("R2 readback", mask_o, v);
    end

    // R5 empty queue, every mode
    wmask(32'hA5C3_0F01);
    for (int m = 0; m < 3; m++) begin
      upd(m);
      chk("R5 count", 32'(stat_cnt), 1);
      chk("R5 word", stat_o, m_mask);
      rd();
      chk("R11 cleared", 32'(stat_cnt), 0);
      chk("R11 held", stat_o, m_mask);
    end

    // R4 immediate sweep; tags with t%7==3 are always zero size
    for (int trial = 0; trial < 48; trial++) begin
      int k;
      wmask(rnd());
      k = int'(rnd() % 10) + 1;
      for (int j = 0; j < k; j++) begin
        int t = int'(rnd() % 32);
        enq(t, (t % 7 == 3) ? 0 : int'(rnd() % 200) + 1);
      end
      upd(0);
      chk("R4 count", 32'(stat_cnt), 1);
      chk("R4 word", stat_o, m_mask & ~mbusy());
      rd();
      drain();
    end

    // R6 any mode
    wmask(32'h6);
    enq(1, 16); enq(2, 32);
    upd(1);
    chk("R3 count cleared", 32'(stat_cnt), 0);
    tick(); tick();
    chk("R6 wait", 32'(stat_cnt), 0);
    ret(2);
    chk("R6 not early", 32'(stat_cnt), 0);
    tick();
    chk("R6 count", 32'(stat_cnt), 1);
    chk("R6 word", stat_o, 32'h4);
    rd(); ret(1); tick(); tick();
    chk("R6 consumed", 32'(stat_cnt), 0);

    // R7 all mode
    wmask(32'hE);
    enq(1, 4); enq(2, 4); enq(3, 4); enq(9, 4);
    upd(2);
    ret(1); tick();
    chk("R7 wait one", 32'(stat_cnt), 0);
    ret(2); tick();
    chk("R7 wait two", 32'(stat_cnt), 0);
    ret(3);
    chk("R7 not early", 32'(stat_cnt), 0);
    tick();
    chk("R7 count", 32'(stat_cnt), 1);
    chk("R7 word", stat_o, 32'hE);
    rd(); ret(9);

    // R10 zero-size entries
    wmask(32'h30);
    enq(4, 0); enq(5, 64);
    upd(0);
    chk("R10 word", stat_o, 32'h10);
    rd(); ret(5);
    upd(2);
    chk("R10 nonempty defers", 32'(stat_cnt), 0);
    tick();
    chk("R10 count", 32'(stat_cnt), 1);
    chk("R10 word all", stat_o, 32'h30);
    rd(); ret(4);

    // R8 rejected values
    wmask(32'h40);
    enq(6, 8);
    upd(1);
    upd(3); upd(32'hFFFF_FFFF); tick();
    chk("R8 count stays 0", 32'(stat_cnt), 0);
    ret(6); tick();
    chk("R8 pending kept", 32'(stat_cnt), 1);
    chk("R8 word", stat_o, 32'h40);
    rd();
    enq(6, 8);
    upd(0);
    upd(7);
    chk("R8 count kept", 32'(stat_cnt), 1);
    chk("R8 word kept", stat_o, 32'h0);
    rd(); ret(6);

    // R13 replace all with any
    wmask(32'h180);
    enq(7, 8); enq(8, 8);
    upd(2); upd(1);
    ret(7); tick();
    chk("R13 count", 32'(stat_cnt), 1);
    chk("R13 word", stat_o, 32'h80);
    rd(); ret(8);

    // R9 full queue
    chk("R9 ready empty", 32'(enq_ready), 1);
    for (int j = 0; j < 16; j++) enq(10, 8);
    chk("R9 ready full", 32'(enq_ready), 0);
    enq(11, 8);
    wmask(32'h0C00);
    upd(0);
    chk("R9 dropped", stat_o, 32'h0800);
    rd();
    ret(10);
    chk("R9 ready again", 32'(enq_ready), 1);
    drain();
    upd(1);
    chk("R9 drained", stat_o, 32'h0C00);
    rd();

    // R12 retire with absent tag
    wmask(32'h2000);
    enq(13, 8);
    ret(12);
    upd(0);
    chk("R12 ignored", stat_o, 32'h0);
    rd(); ret(13);
    upd(0);
    chk("R12 retired", stat_o, 32'h2000);
    rd();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule